// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is a small scratch register file. Four words of four bits are held in flip-flops. One write port and two independent read ports, A and B, are served in the same clock cycle. On every rising clock edge the block registers both read addresses. At the same edge it stores the input data into the addressed word, but only if the write enable is high. A typical use places it beside an adder: one word goes to each operand input, and the sum is written back to any word.

Each read port presents the word selected by the address captured at the last edge. That value includes a write made at the same edge. Each port has its own output enable. When the enable is low, the port's bus is released to high impedance, and the port also lowers a per-bit drive flag. The drive flag lets surrounding logic see the state of the port without relying on tri-state resolution. A synchronous active-high reset clears the storage and the address registers, so the block has a known starting state.

Top module: `dual_read_regfile`

## Requirements
- R1: When reset is high at a rising clock edge, all four words and both captured read addresses become zero, so an enabled port reads 4'h0 after that edge.
- R2: When the write enable is high at a rising edge and reset is low, the data input is stored in the word numbered by the 2-bit write address (0 to 3).
- R3: When the write enable is low at a rising edge, no word changes value.
- R4: Each read port shows the word chosen by its read address as sampled at the most recent rising edge. A change on a read address between edges leaves the outputs unchanged.
- R5: Ports A and B may capture the same address and then show identical data.
- R6: A read that selects the word written at the same edge shows the newly written data once that edge has passed.
- R7: While a port's output enable is high, its four drive flags are 1 and its bus carries the selected word. While the enable is low, the drive flags are 0 and the bus is 'z. The enable acts without waiting for a clock edge.
- R8: A write and two reads of different words proceed in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable, sampled at the edge |
| wr_addr | input | 2 | Word to be written |
| rd_addr_a | input | 2 | Read address for port A, captured at the edge |
| rd_addr_b | input | 2 | Read address for port B, captured at the edge |
| wr_data | input | 4 | Data to be written |
| oe_a | input | 1 | Output enable for port A |
| oe_b | input | 1 | Output enable for port B |
| q_a | output | 4 | Port A data, 'z when disabled |
| q_b | output | 4 | Port B data, 'z when disabled |
| drv_a | output | 4 | Per-bit drive flags for port A |
| drv_b | output | 4 | Per-bit drive flags for port B |

## Verification
The embedded assertions check the following on every cycle:
- the written word takes the data after a write;
- the whole array holds still when no write occurs;
- reset clears the array;
- each captured read address follows its input one edge later;
- two ports with equal captured addresses return equal data;
- a disabled port drops its drive flags.

Some behaviours can only be shown by the bench's scenarios, which compare the outputs each cycle against a behavioural model. These are:
- a read address changed between edges has no effect;
- read-after-write at the same edge;
- a write and two reads of distinct words running together.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int DEF_WORDS  = 4;
    localparam int DEF_WIDTH  = 4;
    localparam int NUM_RPORTS = 2;

    typedef enum int {
        PORT_A = 0,
        PORT_B = 1
    } rport_e;

    function automatic int addr_bits(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction
endpackage

// File: rtl/rf_addr_capture.sv
module rf_addr_capture #(
    parameter int AW = 2,
    parameter int N  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0][AW-1:0] addr_in,
    output logic [N-1:0][AW-1:0] addr_q
);
    for (genvar i = 0; i < N; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) addr_q[i] <= '0;
            else     addr_q[i] <= addr_in[i];
        end
    end
endmodule

// File: rtl/rf_array.sv
module rf_array #(
    parameter int WORDS = 4,
    parameter int WIDTH = 4,
    parameter int AW    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [WIDTH-1:0]             wdata,
    output logic [WORDS-1:0][WIDTH-1:0]  words_o
);
    logic [WORDS-1:0][WIDTH-1:0] store_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                store_q[w] <= '0;
            else if (we && (waddr == AW'(w)))
                store_q[w] <= wdata;
        end
    end

    assign words_o = store_q;

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> words_o[$past(waddr)] == $past(wdata));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(words_o));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> words_o == '0);
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int WORDS = 4,
    parameter int WIDTH = 4,
    parameter int AW    = 2
) (
    input  logic [WORDS-1:0][WIDTH-1:0] words_i,
    input  logic [AW-1:0]               addr_i,
    input  logic                        oe_i,
    output logic [WIDTH-1:0]            data_o,
    output logic [WIDTH-1:0]            drive_o
);
    always_comb begin
        data_o = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr_i == AW'(w)) data_o = words_i[w];
        end
    end

    assign drive_o = {WIDTH{oe_i}};
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile
    import regfile_pkg::*;
#(
    parameter int WORDS = DEF_WORDS,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [addr_bits(WORDS)-1:0]   wr_addr,
    input  logic [addr_bits(WORDS)-1:0]   rd_addr_a,
    input  logic [addr_bits(WORDS)-1:0]   rd_addr_b,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic                          oe_a,
    input  logic                          oe_b,
    output logic [WIDTH-1:0]              q_a,
    output logic [WIDTH-1:0]              q_b,
    output logic [WIDTH-1:0]              drv_a,
    output logic [WIDTH-1:0]              drv_b
);
    localparam int AW = addr_bits(WORDS);
    localparam int NR = NUM_RPORTS;

    logic [NR-1:0][AW-1:0]       raddr_in;
    logic [NR-1:0][AW-1:0]       raddr_q;
    logic [NR-1:0]               oe_vec;
    logic [NR-1:0][WIDTH-1:0]    rdata;
    logic [NR-1:0][WIDTH-1:0]    rdrive;
    logic [WORDS-1:0][WIDTH-1:0] words;

    assign raddr_in[PORT_A] = rd_addr_a;
    assign raddr_in[PORT_B] = rd_addr_b;
    assign oe_vec[PORT_A]   = oe_a;
    assign oe_vec[PORT_B]   = oe_b;

    rf_addr_capture #(.AW(AW), .N(NR)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .addr_in (raddr_in),
        .addr_q  (raddr_q)
    );

    rf_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .words_o (words)
    );

    for (genvar p = 0; p < NR; p++) begin : g_port
        rf_read_port #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_rp (
            .words_i (words),
            .addr_i  (raddr_q[p]),
            .oe_i    (oe_vec[p]),
            .data_o  (rdata[p]),
            .drive_o (rdrive[p])
        );
    end

    assign drv_a = rdrive[PORT_A];
    assign drv_b = rdrive[PORT_B];
    assign q_a   = oe_a ? rdata[PORT_A] : {WIDTH{1'bz}};
    assign q_b   = oe_b ? rdata[PORT_B] : {WIDTH{1'bz}};

    // R4
    addr_a_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> raddr_q[PORT_A] == $past(rd_addr_a));

    // R4
    addr_b_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> raddr_q[PORT_B] == $past(rd_addr_b));

    // R5
    same_word_match_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr_q[PORT_A] == raddr_q[PORT_B]) |-> rdata[PORT_A] == rdata[PORT_B]);

    // R7
    release_a_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_a |-> drv_a == '0);

    // R7
    release_b_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_b |-> drv_b == '0);
endmodule

// File: tb/dual_read_regfile_test.sv
`timescale 1ns/1ps
module dual_read_regfile_test;
    logic       clk = 1'b0;
    logic       rst, wr_en, oe_a, oe_b;
    logic [1:0] wr_addr, rd_addr_a, rd_addr_b;
    logic [3:0] wr_data;
    logic [3:0] q_a, q_b, drv_a, drv_b;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int mdl_mem[4];
    int mdl_ra, mdl_rb;

    always #2 clk = ~clk;

    dual_read_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_data(wr_data),
        .oe_a(oe_a), .oe_b(oe_b), .q_a(q_a), .q_b(q_b),
        .drv_a(drv_a), .drv_b(drv_b)
    );

    task automatic check_val(input string req, input string what,
                             input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_ports(input string req);
        check_val(req, "drv_a", drv_a, {4{oe_a}});
        check_val(req, "drv_b", drv_b, {4{oe_b}});
        if (oe_a) check_val(req, "q_a", q_a, 4'(mdl_mem[mdl_ra]));
        if (oe_b) check_val(req, "q_b", q_b, 4'(mdl_mem[mdl_rb]));
    endtask

    task automatic step(input bit rs, input bit we, input logic [1:0] wa,
                        input logic [1:0] ra, input logic [1:0] rb,
                        input logic [3:0] d, input string req);
        @(negedge clk);
        rst = rs; wr_en = we; wr_addr = wa;
        rd_addr_a = ra; rd_addr_b = rb; wr_data = d;
        @(posedge clk);
        if (rs) begin
            for (int i = 0; i < 4; i++) mdl_mem[i] = 0;
            mdl_ra = 0; mdl_rb = 0;
        end else begin
            if (we) mdl_mem[wa] = int'(d);
            mdl_ra = int'(ra); mdl_rb = int'(rb);
        end
        @(negedge clk);
        compare_ports(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 1; wr_addr = 2'd3; rd_addr_a = 2'd2; rd_addr_b = 2'd1;
        wr_data = 4'hF; oe_a = 1; oe_b = 1;
        for (int i = 0; i < 4; i++) mdl_mem[i] = 0;
        mdl_ra = 0; mdl_rb = 0;

        // R1: reset with a write pending still clears everything
        step(1, 1, 2'd3, 2'd2, 2'd1, 4'hF, "R1");
        step(1, 1, 2'd2, 2'd3, 2'd3, 4'hE, "R1");
        check_val("R1", "q_a after reset", q_a, 4'h0);

        // R2 R8: fill words while reading other words
        step(0, 1, 2'd0, 2'd1, 2'd2, 4'hA, "R2");
        step(0, 1, 2'd1, 2'd0, 2'd3, 4'h5, "R8");
        step(0, 1, 2'd2, 2'd0, 2'd1, 4'hC, "R8");
        step(0, 1, 2'd3, 2'd2, 2'd1, 4'h3, "R2");
        check_val("R2", "q_a word2", q_a, 4'hC);

        // R4 R5: all address pairs, including equal ones
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                step(0, 0, 2'd0, 2'(a), 2'(b), 4'h0, (a == b) ? "R5" : "R4");

        // R3: write enable low with different data leaves words intact
        step(0, 0, 2'd1, 2'd1, 2'd1, 4'hF, "R3");
        check_val("R3", "q_a word1 kept", q_a, 4'h5);
        step(0, 0, 2'd2, 2'd2, 2'd3, 4'h0, "R3");

        // R6: read of the word written at the same edge
        step(0, 1, 2'd2, 2'd2, 2'd0, 4'h9, "R6");
        check_val("R6", "q_a new data", q_a, 4'h9);

        // R4: address change between edges has no effect
        @(negedge clk);
        rd_addr_a = 2'd3; rd_addr_b = 2'd1; wr_en = 0;
        #1;
        compare_ports("R4");
        check_val("R4", "q_a held", q_a, 4'h9);
        @(posedge clk);
        mdl_ra = 3; mdl_rb = 1;
        @(negedge clk);
        compare_ports("R4");

        // R7: output enables act without a clock edge
        oe_a = 0; #1;
        check_val("R7", "drv_a low", drv_a, 4'h0);
        check_val("R7", "drv_b high", drv_b, 4'hF);
        oe_b = 0; #1;
        check_val("R7", "drv_b low", drv_b, 4'h0);
        step(0, 1, 2'd0, 2'd0, 2'd0, 4'h6, "R7");
        oe_a = 1; oe_b = 1; #1;
        compare_ports("R7");

        // R8: random mix of writes and reads
        for (int n = 0; n < 300; n++) begin
            logic [1:0] wa, ra, rb;
            logic [3:0] d;
            bit we;
            we = 1'($urandom_range(0, 1));
            wa = 2'($urandom_range(0, 3));
            ra = 2'($urandom_range(0, 3));
            rb = 2'($urandom_range(0, 3));
            d  = 4'($urandom_range(0, 15));
            oe_a = (n % 7) != 3;
            oe_b = (n % 5) != 2;
            step(0, we, wa, ra, rb, d, "R8");
        end
        oe_a = 1; oe_b = 1;

        // R1: reset mid-run
        step(1, 0, 2'd0, 2'd3, 2'd2, 4'h0, "R1");
        for (int a = 0; a < 4; a++)
            step(0, 0, 2'd0, 2'(a), 2'(3 - a), 4'h0, "R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule